// File: doc/BRIEF.md
# Reconfigurable Transpose Pixel Array for an Edge Filter

This block is a small register array of 4 rows by 8 columns of 8-bit pixels. It sits between the on-chip pixel memory and one parallel 8-pixel one-dimensional edge filter. It holds the pixels of two 4x4 blocks that share an edge, so the same filter can smooth both vertical edges and horizontal edges. The filter arithmetic and the memory are outside this block.

The array can shift in one of two directions, chosen at run time. It shifts downward when whole 8-pixel rows come in from the filter. It shifts rightward when 4-pixel memory words come in as columns. Entering data one way and leaving it the other way transposes the block pair.

A 2-bit mode input selects the phase:
- **Horizontal pass (8 cycles).** Memory rows go to the filter, and the filtered rows are gathered in the array. The buffered result is then written back to memory.
- **Vertical load/store (8 cycles).** One fresh 4-pixel word enters the array each cycle. At the same time, one previously filtered word leaves toward memory.
- **Vertical filter (4 cycles).** The stored vertical lines go to the filter, and the filter results are caught again.

Top module: `pix_xpose_array`

## Requirements
- R1: While `rst` is high and afterwards, until data is loaded, every array cell is zero. `mem_out_o`, `mem_vld_o` and `flt_feed_o` are zero while `rst` is high and while idle.
- R2: Horizontal mode (`mode_i`=1) lasts 8 cycles.
  - In cycles 0..3, the 8-lane row on `flt_res_i` is captured.
  - In cycles 4..7, those rows appear on `mem_out_o` in the order they were captured, with `mem_vld_o` high. `mem_vld_o` is low in cycles 0..3.
- R3: In horizontal cycles 0..3, `flt_feed_o` equals `mem_in_i`. Lane j is bits [8j+7:8j].
- R4: Vertical load/store mode (`mode_i`=2) lasts 8 cycles. In cycle k, lanes 0..3 of `mem_in_i` are taken as word k, with lane x being pixel x.
- R5: Vertical filter mode (`mode_i`=3) lasts 4 cycles.
  - In cycle k, lane j of `flt_feed_o` is pixel (3-k) of word (7-j) from the latest load/store phase.
  - The `flt_res_i` value of cycle k is captured as filtered line k.
- R6: The first load/store phase after a completed filter phase has `mem_vld_o` high in all 8 cycles. In its cycle k, lane i (0..3) of `mem_out_o` is lane (7-k) of filtered line (3-i). Lanes 4..7 are zero.
- R7: `mem_out_o` is zero whenever `mem_vld_o` is low. A load/store phase that does not follow a filter phase keeps `mem_vld_o` low.
- R8: `mode_i` is sampled only in the first cycle of a phase. Changes to it later in the phase have no effect.
- R9: In idle (`mode_i`=0), the array contents hold regardless of `mem_in_i` and `flt_res_i`.
- R10: `flt_feed_o` is zero in idle, in the load/store phase and in horizontal cycles 4..7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | Phase select: 0 idle, 1 horizontal, 2 vertical load/store, 3 vertical filter |
| mem_in_i | input | 64 | Pixels read from memory (8 lanes; lanes 0..3 used in load/store) |
| flt_res_i | input | 64 | Filtered 8-pixel line returned by the filter |
| flt_feed_o | output | 64 | 8-pixel line sent to the filter |
| mem_out_o | output | 64 | Pixels to be written to memory |
| mem_vld_o | output | 1 | High when `mem_out_o` carries data to write |

## Verification
The vertical chain loads eight words per pass, each built from a distinct arithmetic pattern of seed, row and lane. Its values show whether the transposition keeps both the word order and the pixel order. The filter stub adds a different constant in each lane, so a lane that is swapped or reversed shows up as a wrong value rather than a coincidental match. Horizontal passes with several seeds confirm that rows leave in arrival order. Runs that toggle `mode_i` mid-phase, insert idle gaps between filtering and storing, and issue a load/store with nothing filtered separate correct mode latching, holding and valid gating from a design that follows the live mode input.

// File: rtl/pxa_pkg.sv
package pxa_pkg;

    typedef enum logic [1:0] {
        PM_IDLE  = 2'd0,
        PM_HORZ  = 2'd1,
        PM_VLDST = 2'd2,
        PM_VFILT = 2'd3
    } pxa_mode_e;

    typedef struct packed {
        logic shift_dn;   // rows move down, new row enters at the top
        logic shift_rt;   // columns move right, new column enters at the left
        logic feed_mem;   // memory row goes straight to the filter
        logic feed_row;   // bottom array row goes to the filter
        logic emit_row;   // bottom row goes to memory
        logic emit_col;   // right column goes to memory
        logic set_held;   // a filter phase has just completed
        logic clr_held;   // stored results have been written out
    } pxa_ctl_t;

    function automatic int unsigned max2(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/pxa_ctrl.sv
module pxa_ctrl
    import pxa_pkg::*;
#(
    parameter int ROWS = 4,
    parameter int COLS = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] mode_i,
    output pxa_ctl_t   ctl_o
);
    localparam int HLEN   = 2 * ROWS;
    localparam int VLEN   = COLS;
    localparam int FLEN   = ROWS;
    localparam int MAXLEN = int'(max2(HLEN, VLEN));
    localparam int CW     = $clog2(MAXLEN);

    logic [CW-1:0] cnt_q, cnt_d;
    pxa_mode_e     mode_q, eff;
    logic          held_q;
    logic          last;

    always_comb begin
        eff   = (cnt_q == '0) ? pxa_mode_e'(mode_i) : mode_q;
        ctl_o = '0;
        last  = 1'b1;
        unique case (eff)
            PM_HORZ: begin
                last           = (cnt_q == CW'(HLEN - 1));
                ctl_o.shift_dn = 1'b1;
                if (cnt_q < CW'(ROWS)) ctl_o.feed_mem = 1'b1;
                else                   ctl_o.emit_row = 1'b1;
            end
            PM_VLDST: begin
                last           = (cnt_q == CW'(VLEN - 1));
                ctl_o.shift_rt = 1'b1;
                ctl_o.emit_col = held_q;
                ctl_o.clr_held = last;
            end
            PM_VFILT: begin
                last           = (cnt_q == CW'(FLEN - 1));
                ctl_o.shift_dn = 1'b1;
                ctl_o.feed_row = 1'b1;
                ctl_o.set_held = last;
            end
            default: ;
        endcase
        cnt_d = last ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            mode_q <= PM_IDLE;
            held_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_d;
            mode_q <= eff;
            if (ctl_o.set_held)      held_q <= 1'b1;
            else if (ctl_o.clr_held) held_q <= 1'b0;
        end
    end

    // R8
    mode_lock_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt_q != '0) |=> ((cnt_q == '0) || $stable(mode_q)));

    // R6
    held_src_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(held_q) |-> (mode_q == PM_VFILT));

endmodule

// File: rtl/pxa_cells.sv
module pxa_cells #(
    parameter int ROWS = 4,
    parameter int COLS = 8,
    parameter int PW   = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 shift_dn,
    input  logic                 shift_rt,
    input  logic [COLS*PW-1:0]   row_in,
    input  logic [ROWS*PW-1:0]   col_in,
    output logic [COLS*PW-1:0]   bot_row_o,
    output logic [ROWS*PW-1:0]   rt_col_o
);
    localparam int NCELL = ROWS * COLS;

    logic [PW-1:0] cell_q [ROWS][COLS];
    logic [PW-1:0] nxt    [ROWS][COLS];
    logic [NCELL*PW-1:0] flat;

    always_comb begin
        for (int r = 0; r < ROWS; r++) begin
            for (int c = 0; c < COLS; c++) begin
                nxt[r][c] = cell_q[r][c];
                if (shift_dn) begin
                    if (r == 0) nxt[r][c] = row_in[c*PW +: PW];
                    else        nxt[r][c] = cell_q[r-1][c];
                end else if (shift_rt) begin
                    if (c == 0) nxt[r][c] = col_in[r*PW +: PW];
                    else        nxt[r][c] = cell_q[r][c-1];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cell_q <= '{default: '0};
        else     cell_q <= nxt;
    end

    for (genvar c = 0; c < COLS; c++) begin : g_bot
        assign bot_row_o[c*PW +: PW] = cell_q[ROWS-1][c];
    end
    for (genvar r = 0; r < ROWS; r++) begin : g_rt
        assign rt_col_o[r*PW +: PW] = cell_q[r][COLS-1];
    end
    for (genvar r = 0; r < ROWS; r++) begin : g_fr
        for (genvar c = 0; c < COLS; c++) begin : g_fc
            assign flat[(r*COLS+c)*PW +: PW] = cell_q[r][c];
        end
    end

    // R4
    dir_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(shift_dn && shift_rt));

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(shift_dn || shift_rt) |=> $stable(flat));

    for (genvar r = 0; r < ROWS; r++) begin : g_rchk
        // R4
        rt_step_chk: assert property (@(posedge clk) disable iff (rst)
            shift_rt |=> (cell_q[r][1] == $past(cell_q[r][0])));
    end

    for (genvar c = 0; c < COLS; c++) begin : g_dchk
        // R5
        dn_step_chk: assert property (@(posedge clk) disable iff (rst)
            shift_dn |=> (cell_q[1][c] == $past(cell_q[0][c])));
    end

endmodule

// File: rtl/pix_xpose_array.sv
module pix_xpose_array
    import pxa_pkg::*;
#(
    parameter int ROWS = 4,
    parameter int COLS = 8,
    parameter int PW   = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [1:0]           mode_i,
    input  logic [COLS*PW-1:0]   mem_in_i,
    input  logic [COLS*PW-1:0]   flt_res_i,
    output logic [COLS*PW-1:0]   flt_feed_o,
    output logic [COLS*PW-1:0]   mem_out_o,
    output logic                 mem_vld_o
);
    localparam int LW = COLS * PW;
    localparam int CWB = ROWS * PW;

    pxa_ctl_t       ctl;
    logic [LW-1:0]  row_in, bot_row;
    logic [CWB-1:0] col_in, rt_col;

    pxa_ctrl #(.ROWS(ROWS), .COLS(COLS)) ctrl_i (
        .clk    (clk),
        .rst    (rst),
        .mode_i (mode_i),
        .ctl_o  (ctl)
    );

    assign row_in = (ctl.feed_mem || ctl.feed_row) ? flt_res_i : '0;
    assign col_in = mem_in_i[CWB-1:0];

    pxa_cells #(.ROWS(ROWS), .COLS(COLS), .PW(PW)) cells_i (
        .clk       (clk),
        .rst       (rst),
        .shift_dn  (ctl.shift_dn),
        .shift_rt  (ctl.shift_rt),
        .row_in    (row_in),
        .col_in    (col_in),
        .bot_row_o (bot_row),
        .rt_col_o  (rt_col)
    );

    always_comb begin
        flt_feed_o = '0;
        if (ctl.feed_mem)      flt_feed_o = mem_in_i;
        else if (ctl.feed_row) flt_feed_o = bot_row;

        mem_out_o = '0;
        if (ctl.emit_row)      mem_out_o = bot_row;
        else if (ctl.emit_col) mem_out_o[CWB-1:0] = rt_col;
        mem_vld_o = ctl.emit_row || ctl.emit_col;
    end

    // R7
    vld_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !mem_vld_o |-> (mem_out_o == '0));

    // R2
    drain_after_fill_chk: assert property (@(posedge clk) disable iff (rst)
        ctl.emit_row |-> $past(ctl.shift_dn));

endmodule

// File: tb/pix_xpose_array_tb_top.sv
module pix_xpose_array_tb_top;
    localparam int PW = 8, COLS = 8, ROWS = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  mode = 2'd0;
    logic [63:0] mem_in = '0;
    logic [63:0] flt_res, flt_feed, mem_out;
    logic        mem_vld;

    int checks = 0;
    int errors = 0;

    logic [7:0] words [8][4];
    logic [7:0] fres  [4][8];

    always #5 clk = ~clk;

    pix_xpose_array #(.ROWS(ROWS), .COLS(COLS), .PW(PW)) dut_i (
        .clk        (clk),
        .rst        (rst),
        .mode_i     (mode),
        .mem_in_i   (mem_in),
        .flt_res_i  (flt_res),
        .flt_feed_o (flt_feed),
        .mem_out_o  (mem_out),
        .mem_vld_o  (mem_vld)
    );

    function automatic logic [7:0] lane_k(int j);
        return 8'(j * 3 + 1);
    endfunction

    function automatic logic [7:0] pv(int s, int y, int x);
        return 8'(s * 37 + y * 19 + x * 5 + 3);
    endfunction

    // filter stub: per-lane offset
    always_comb begin
        for (int j = 0; j < 8; j++) flt_res[j*8 +: 8] = flt_feed[j*8 +: 8] + lane_k(j);
    end

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic run_idle(int n, int s);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            mode = 2'd0;
            for (int x = 0; x < 8; x++) mem_in[x*8 +: 8] = pv(s + 50, k, x);
            #1;
            chk("R10 idle feed", flt_feed, '0);
            chk("R1 idle out", mem_out, '0);
            chk("R7 idle vld", {63'd0, mem_vld}, 64'd0);
        end
    endtask

    task automatic run_horz(int s, bit perturb);
        logic [63:0] rowv [4];
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            mode = (k == 0 || !perturb) ? 2'd1 : 2'((k * 3 + 2) % 4);
            for (int x = 0; x < 8; x++) mem_in[x*8 +: 8] = pv(s, k, x);
            #1;
            if (k < 4) begin
                for (int x = 0; x < 8; x++) rowv[k][x*8 +: 8] = pv(s, k, x) + lane_k(x);
                chk("R3 horz feed", flt_feed, mem_in);
                chk("R2 horz vld low", {63'd0, mem_vld}, 64'd0);
            end else begin
                chk(perturb ? "R8 horz out" : "R2 horz out", mem_out, rowv[k-4]);
                chk("R2 horz vld high", {63'd0, mem_vld}, 64'd1);
                chk("R10 horz drain feed", flt_feed, '0);
            end
        end
    endtask

    task automatic run_vls(int s, bit exp_vld);
        logic [63:0] e;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            mode = 2'd2;
            for (int x = 0; x < 8; x++) mem_in[x*8 +: 8] = pv(s, k, x);
            for (int x = 0; x < 4; x++) words[k][x] = pv(s, k, x);
            #1;
            e = '0;
            if (exp_vld)
                for (int i = 0; i < 4; i++) e[i*8 +: 8] = fres[3-i][7-k];
            chk(exp_vld ? "R6 store data" : "R7 store data", mem_out, e);
            chk(exp_vld ? "R6 store vld" : "R7 store vld", {63'd0, mem_vld}, {63'd0, exp_vld});
            chk("R10 vls feed", flt_feed, '0);
        end
    endtask

    task automatic run_vfilt(bit perturb, string tag);
        logic [63:0] e;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            mode = (k == 0 || !perturb) ? 2'd3 : 2'((k + 1) % 3);
            for (int x = 0; x < 8; x++) mem_in[x*8 +: 8] = pv(k + 77, k, x);
            #1;
            for (int j = 0; j < 8; j++) begin
                e[j*8 +: 8]  = words[7-j][3-k];
                fres[k][j]   = words[7-j][3-k] + lane_k(j);
            end
            chk(perturb ? "R8 vfilt feed" : tag, flt_feed, e);
            chk("R5 vfilt vld", {63'd0, mem_vld}, 64'd0);
        end
    endtask

    initial begin
        #100000;
        errors++;
        $display("FAIL watchdog act=timeout exp=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int k = 0; k < 8; k++)
            for (int x = 0; x < 4; x++) words[k][x] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        chk("R1 reset out", mem_out, '0);
        chk("R1 reset vld", {63'd0, mem_vld}, 64'd0);
        chk("R1 reset feed", flt_feed, '0);
        rst = 1'b0;
        run_idle(2, 0);
        run_vfilt(1'b0, "R1 reset array");
        run_vls(1, 1'b1);
        for (int s = 2; s < 10; s++) begin
            run_vfilt(s[0], "R5 vfilt feed");
            run_idle(s % 3, s);   // R9 gap before store
            run_vls(s, 1'b1);
        end
        run_vls(30, 1'b0);
        for (int s = 0; s < 6; s++) begin
            run_horz(s + 40, s[0]);
            run_idle(1, s);
        end
        run_vls(60, 1'b0);
        run_vfilt(1'b0, "R4 load order");
        run_idle(3, 61);
        run_vls(62, 1'b1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule